// File: doc/BRIEF.md
# Configurable Synchronous FIFO Controller

This block is a single-clock first-in first-out buffer with a 36-bit data path, built on an inferred dual-port RAM. Two timing modes are available. In standard mode a word comes out only after a read request. In fall-through mode the oldest word sits on the output before any request, and a read request takes it away. The mode is captured while master reset is held low. Master reset and partial reset are both synchronous and active low.

Two status outputs report how close the buffer is to empty and to full. Each compares against its own offset. After master reset both offsets take one of five preset values. Software can then replace them in parallel from the write-data bus, or bit by bit over a serial pair, depending on a programming method captured at master reset. Partial reset empties the buffer but keeps the mode, the method and the offsets. A retransmit pulse rewinds the read side to the first word written since the last reset. DEPTH must be a power of two.

Top module: `cfgFifo`

## Requirements
- R1: While rstMasterN is low, cfgFwft, cfgPresetSel and cfgProgMode are captured and the buffer is emptied. After release, rdFlag=0, wrFlag=1, almostEmpty=1 and almostFull=0.
- R2: In standard mode (cfgFwft=0) rdFlag is 1 whenever at least one word is stored. A rdEn with rdFlag=1 places the oldest word on rdData after that clock edge. Words leave in write order.
- R3: In fall-through mode (cfgFwft=1) a word written into an empty buffer appears on rdData, with rdFlag=1, two edges after its write edge and without any rdEn. A rdEn while rdFlag=1 consumes that word. Without rdEn the word stays.
- R4: wrFlag is 0 while DEPTH words are held, and a write is ignored then. A read is ignored while rdFlag=0.
- R5: A write and a read on the same edge are both accepted when the buffer is neither full nor unreadable. The occupancy is then unchanged and the read returns the old head.
- R6: cfgPresetSel loads both offsets at master reset: code 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256, and 4 to 7 give 1024.
- R7: almostEmpty is 1 exactly when occupancy <= empty offset. almostFull is 1 exactly when DEPTH - occupancy <= full offset. In fall-through mode the occupancy includes the word shown on rdData.
- R8: With cfgProgMode=1 (parallel), ofsLoad=1 on an edge sets the empty offset to wrData[OFS_W-1:0] and the full offset to wrData[18+OFS_W-1:18], with OFS_W = max(log2(DEPTH)+1, 11). With any other method, ofsLoad has no effect.
- R9: With cfgProgMode=2 (serial), each edge with serEn=1 takes one serData bit, LSB first. The first OFS_W bits go to the empty offset and the next OFS_W bits to the full offset. Edges with serEn=0 take nothing, and bits beyond 2*OFS_W are ignored until the next master reset.
- R10: A low rstPartialN empties the buffer but keeps the timing mode, the programming method and both offsets.
- R11: A one-edge retx pulse moves the read side back to the first word written since the last reset, so that every word written since then can be read again. This is valid when no more than DEPTH words were written since that reset. wrEn and rdEn are ignored on that edge. In fall-through mode the shown word is dropped and refetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstMasterN | input | 1 | Master reset, synchronous, active low; captures the configuration |
| rstPartialN | input | 1 | Partial reset, synchronous, active low; keeps the configuration |
| cfgFwft | input | 1 | Timing mode captured at master reset: 1 = fall-through |
| cfgPresetSel | input | 3 | Offset preset code captured at master reset |
| cfgProgMode | input | 2 | Offset programming method: 0 preset, 1 parallel, 2 serial, 3 none |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data; also carries parallel offsets |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Read data |
| retx | input | 1 | Retransmit pulse |
| ofsLoad | input | 1 | Parallel offset load strobe |
| serEn | input | 1 | Serial offset bit enable |
| serData | input | 1 | Serial offset bit |
| rdFlag | output | 1 | Standard: not empty; fall-through: output word valid |
| wrFlag | output | 1 | Not full: a write is accepted |
| almostEmpty | output | 1 | Occupancy at or below the empty offset |
| almostFull | output | 1 | Free space at or below the full offset |

## Verification
A write and a read can fall on the same edge, and so can a retransmit and a write. The bench provokes the first with a stored head and a request on both sides in one cycle, in each timing mode. It judges the result by the word returned and by later draining the whole contents in order against a queue. For the second it holds wrEn high during the retx pulse. The replay must then contain exactly the words written before the pulse, and the flags must match the occupancy computed from that history.

// File: rtl/cfgFifoPkg.sv
package cfgFifoPkg;

  typedef enum logic [1:0] {
    PROG_PRESET   = 2'd0,
    PROG_PARALLEL = 2'd1,
    PROG_SERIAL   = 2'd2,
    PROG_NONE     = 2'd3
  } progMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ramWr;
    logic outLoad;
  } fifoStrobes_t;

  // bit position of the full offset inside the parallel load word
  localparam int AF_FIELD_LSB = 18;

  function automatic int unsigned presetOffset(input logic [2:0] code);
    case (code)
      3'd0:    presetOffset = 8;
      3'd1:    presetOffset = 16;
      3'd2:    presetOffset = 64;
      3'd3:    presetOffset = 256;
      default: presetOffset = 1024;
    endcase
  endfunction

endpackage

// File: rtl/cfgFifoCtrl.sv
module cfgFifoCtrl
  import cfgFifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048
) (
  input  logic                          clk,
  input  logic                          rstMasterN,
  input  logic                          rstPartialN,
  input  logic                          cfgFwft,
  input  logic [2:0]                    cfgPresetSel,
  input  logic [1:0]                    cfgProgMode,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic                          retx,
  input  logic                          ofsLoad,
  input  logic [DATA_W-1:0]             ofsBus,
  input  logic                          serEn,
  input  logic                          serData,
  output fifoStrobes_t                  stb,
  output logic [$clog2(DEPTH)-1:0]      wrAddr,
  output logic [$clog2(DEPTH)-1:0]      rdAddr,
  output logic                          fwftMode,
  output logic                          rdFlag,
  output logic                          wrFlag,
  output logic                          almostEmpty,
  output logic                          almostFull
);
  localparam int AW       = $clog2(DEPTH);
  localparam int CNT_W    = AW + 1;
  localparam int OFS_W    = (CNT_W > 11) ? CNT_W : 11;
  localparam int SER_BITS = 2 * OFS_W;
  localparam int SC_W     = $clog2(SER_BITS + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] wrPtr, rdPtr, ramCount, occ, freeSpace;
  logic             outValid;
  progMode_e        progMode;
  logic [OFS_W-1:0] aeOfs, afOfs, aeNext, afNext;
  logic [SC_W-1:0]  serCnt;
  logic             serShift, active;
  logic             wrFire, stdRead, consume, fwLoad;

  assign active    = rstMasterN & rstPartialN;
  assign ramCount  = wrPtr - rdPtr;
  assign occ       = ramCount + CNT_W'(outValid);
  assign freeSpace = DEPTH_C - occ;

  assign wrFire  = active & wrEn & ~retx & (occ < DEPTH_C);
  assign stdRead = active & ~fwftMode & rdEn & ~retx & (ramCount != '0);
  assign consume = active & fwftMode & rdEn & ~retx & outValid;
  assign fwLoad  = active & fwftMode & ~retx & (ramCount != '0) & (~outValid | consume);

  assign stb.ramWr   = wrFire;
  assign stb.outLoad = stdRead | fwLoad;
  assign wrAddr      = wrPtr[AW-1:0];
  assign rdAddr      = rdPtr[AW-1:0];

  assign rdFlag      = fwftMode ? outValid : (ramCount != '0);
  assign wrFlag      = occ < DEPTH_C;
  assign almostEmpty = OFS_W'(occ) <= aeOfs;
  assign almostFull  = OFS_W'(freeSpace) <= afOfs;

  // offset programming: parallel word or one serial bit per enabled edge
  always_comb begin
    aeNext   = aeOfs;
    afNext   = afOfs;
    serShift = 1'b0;
    if (progMode == PROG_PARALLEL && ofsLoad) begin
      aeNext = ofsBus[OFS_W-1:0];
      afNext = ofsBus[AF_FIELD_LSB +: OFS_W];
    end
    if (progMode == PROG_SERIAL && serEn && serCnt < SC_W'(SER_BITS)) begin
      serShift = 1'b1;
      for (int i = 0; i < OFS_W; i++) begin
        if (serCnt == SC_W'(i))         aeNext[i] = serData;
        if (serCnt == SC_W'(i + OFS_W)) afNext[i] = serData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstMasterN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      outValid <= 1'b0;
      fwftMode <= cfgFwft;
      progMode <= progMode_e'(cfgProgMode);
      aeOfs    <= OFS_W'(presetOffset(cfgPresetSel));
      afOfs    <= OFS_W'(presetOffset(cfgPresetSel));
      serCnt   <= '0;
    end else if (!rstPartialN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      outValid <= 1'b0;
    end else begin
      if (wrFire) wrPtr <= wrPtr + 1'b1;
      if (retx) begin
        rdPtr    <= '0;
        outValid <= 1'b0;
      end else begin
        if (stb.outLoad) rdPtr <= rdPtr + 1'b1;
        if (fwftMode) outValid <= fwLoad | (outValid & ~consume);
      end
      aeOfs <= aeNext;
      afOfs <= afNext;
      if (serShift) serCnt <= serCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfgFifoData.sv
module cfgFifoData
  import cfgFifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048
) (
  input  logic                     clk,
  input  fifoStrobes_t             stb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.ramWr)   mem[wrAddr] <= wrData;
    if (stb.outLoad) rdData      <= mem[rdAddr];
  end

endmodule

// File: rtl/cfgFifo.sv
module cfgFifo
  import cfgFifoPkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rstMasterN,
  input  logic              rstPartialN,
  input  logic              cfgFwft,
  input  logic [2:0]        cfgPresetSel,
  input  logic [1:0]        cfgProgMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              retx,
  input  logic              ofsLoad,
  input  logic              serEn,
  input  logic              serData,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobes_t    stb;
  logic [AW-1:0]   wrAddr, rdAddr;
  logic            fwftMode;

  cfgFifoCtrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstMasterN(rstMasterN), .rstPartialN(rstPartialN),
    .cfgFwft(cfgFwft), .cfgPresetSel(cfgPresetSel), .cfgProgMode(cfgProgMode),
    .wrEn(wrEn), .rdEn(rdEn), .retx(retx), .ofsLoad(ofsLoad), .ofsBus(wrData),
    .serEn(serEn), .serData(serData), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fwftMode(fwftMode), .rdFlag(rdFlag), .wrFlag(wrFlag),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  cfgFifoData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/cfgFifoChk.sv
module cfgFifoChk (
  input logic clk,
  input logic rstMasterN,
  input logic rstPartialN,
  input logic wrEn,
  input logic rdEn,
  input logic retx,
  input logic fwftMode,
  input logic rdFlag,
  input logic wrFlag,
  input logic almostEmpty,
  input logic almostFull
);
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    (!wrFlag && wrEn && !rdEn && !retx) |=> !wrFlag); // R4

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    (!fwftMode && !rdFlag && !wrEn && !retx) |=> !rdFlag); // R2

  AST_FWFT_WORD_STAYS: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    (fwftMode && rdFlag && !rdEn && !retx) |=> rdFlag); // R3

  AST_AE_AT_EMPTY: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    (!fwftMode && !rdFlag) |-> almostEmpty); // R7

  AST_AF_AT_FULL: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    !wrFlag |-> almostFull); // R7

  AST_PRST_EMPTIES: assert property (@(posedge clk) disable iff (!rstMasterN)
    $rose(rstPartialN) |-> (!rdFlag && wrFlag && almostEmpty)); // R10

  AST_RETX_DROPS_WORD: assert property (@(posedge clk) disable iff (!rstMasterN || !rstPartialN)
    (fwftMode && retx) |=> !rdFlag); // R11
endmodule

bind cfgFifo cfgFifoChk chk_i (
  .clk(clk), .rstMasterN(rstMasterN), .rstPartialN(rstPartialN),
  .wrEn(wrEn), .rdEn(rdEn), .retx(retx), .fwftMode(fwftMode),
  .rdFlag(rdFlag), .wrFlag(wrFlag), .almostEmpty(almostEmpty), .almostFull(almostFull)
);

// File: tb/cfgFifo_tb_top.sv
`timescale 1ns/1ps
module cfgFifo_tb_top;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 2048;
  localparam int OFS_W  = 12;

  logic clk = 1'b0;
  logic rstMasterN = 1'b0, rstPartialN = 1'b1;
  logic cfgFwft = 1'b0;
  logic [2:0] cfgPresetSel = '0;
  logic [1:0] cfgProgMode = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, retx = 1'b0, ofsLoad = 1'b0, serEn = 1'b0, serData = 1'b0;
  logic [DATA_W-1:0] wrData = '0, rdData;
  logic rdFlag, wrFlag, almostEmpty, almostFull;

  always #2.5 clk = ~clk;

  cfgFifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (.*);

  int nChk = 0, nBad = 0, seq = 1;
  bit fwM = 0, done = 0;
  int aeM, afM;
  logic [DATA_W-1:0] q[$], hist[$];

  function automatic logic [DATA_W-1:0] mkWord(input int n);
    logic [31:0] h = 32'(n) * 32'h9E37_79B9;
    return {4'(n) ^ 4'h9, h};
  endfunction

  function automatic int presetVal(input int code);
    case (code) 0: return 8; 1: return 16; 2: return 64; 3: return 256; default: return 1024; endcase
  endfunction

  task automatic step; @(posedge clk); #1; endtask

  task automatic chk(input string r, input string what, input logic [63:0] got, input logic [63:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, got, exp);
    end
  endtask

  task automatic masterReset(input bit fw, input int code, input int pm);
    cfgFwft = fw; cfgPresetSel = 3'(code); cfgProgMode = 2'(pm);
    rstMasterN = 1'b0; step; step; rstMasterN = 1'b1; step;
    q.delete(); hist.delete(); fwM = fw; aeM = presetVal(code); afM = aeM;
  endtask

  task automatic settle; if (fwM) begin step; step; end endtask

  task automatic chkFlags(input string r);
    int n = q.size();
    settle;
    chk(r, "almostEmpty", almostEmpty, n <= aeM);
    chk(r, "almostFull", almostFull, (DEPTH - n) <= afM);
    chk(r, "wrFlag", wrFlag, n < DEPTH);
    chk(r, "rdFlag", rdFlag, n > 0);
  endtask

  task automatic fillTo(input int t);
    while (q.size() < t) begin
      wrEn = 1'b1; wrData = mkWord(seq);
      q.push_back(wrData); hist.push_back(wrData); seq++;
      step;
    end
    wrEn = 1'b0;
  endtask

  task automatic readOne(input string r);
    logic [DATA_W-1:0] e = q.pop_front();
    if (fwM) begin
      chk(r, "rdFlag before read", rdFlag, 1);
      chk(r, "shown word", rdData, e);
      rdEn = 1'b1; step; rdEn = 1'b0;
    end else begin
      rdEn = 1'b1; step; rdEn = 1'b0;
      chk(r, "read word", rdData, e);
    end
  endtask

  task automatic serialBits(input int v, input int nb);
    for (int i = 0; i < nb; i++) begin
      serEn = 1'b1; serData = v[i]; step;
    end
    serEn = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] hold, w;
    step; step;
    // R1: reset state
    masterReset(0, 0, 0);
    chk("R1", "rdFlag", rdFlag, 0); chk("R1", "wrFlag", wrFlag, 1);
    chk("R1", "almostEmpty", almostEmpty, 1); chk("R1", "almostFull", almostFull, 0);

    // R6 / R7 / R4: preset sweep over every code
    for (int code = 0; code < 8; code++) begin
      int p = presetVal(code);
      masterReset(0, code, 0);
      fillTo(p);             chkFlags("R6");
      fillTo(p + 1);         chkFlags("R6");
      fillTo(DEPTH - p - 1); chkFlags("R7");
      fillTo(DEPTH - p);     chkFlags("R7");
      fillTo(DEPTH);         chkFlags("R4");
      if (code == 0) begin
        wrEn = 1'b1; wrData = 36'hBAD_BAD_BAD; step; wrEn = 1'b0;
        chk("R4", "wrFlag after write at full", wrFlag, 0);
        while (q.size() > 0) readOne("R2");
        chkFlags("R2");
        hold = rdData;
        rdEn = 1'b1; step; rdEn = 1'b0;
        chk("R4", "rdData after read of empty", rdData, hold);
        chk("R4", "rdFlag after read of empty", rdFlag, 0);
      end
    end

    // R5: simultaneous write and read, standard mode
    masterReset(0, 0, 0);
    fillTo(3);
    w = mkWord(seq); seq++;
    wrEn = 1'b1; wrData = w; rdEn = 1'b1; step; wrEn = 1'b0; rdEn = 1'b0;
    chk("R5", "head on simultaneous read", rdData, q.pop_front());
    q.push_back(w);
    chkFlags("R5");
    while (q.size() > 0) readOne("R5");

    // R3: fall-through mode
    masterReset(1, 1, 0);
    w = mkWord(seq); seq++;
    wrEn = 1'b1; wrData = w; step; wrEn = 1'b0;
    q.push_back(w);
    chk("R3", "rdFlag one edge after write", rdFlag, 0);
    step;
    chk("R3", "rdFlag two edges after write", rdFlag, 1);
    chk("R3", "word shown without read", rdData, w);
    fillTo(20); chkFlags("R3");
    for (int i = 0; i < 5; i++) readOne("R3");
    chkFlags("R7");
    w = mkWord(seq); seq++;
    wrEn = 1'b1; wrData = w; rdEn = 1'b1; step; wrEn = 1'b0; rdEn = 1'b0;
    void'(q.pop_front()); q.push_back(w);
    chk("R5", "fall-through next head", rdData, q[0]);
    chkFlags("R5");
    while (q.size() > 0) readOne("R3");
    chkFlags("R3");

    // R8: parallel offset load, and ignored under preset method
    masterReset(0, 0, 1);
    ofsLoad = 1'b1; wrData = (36'(20) << 18) | 36'(5); step; ofsLoad = 1'b0;
    aeM = 5; afM = 20;
    fillTo(5); chkFlags("R8"); fillTo(6); chkFlags("R8");
    fillTo(DEPTH - 21); chkFlags("R8"); fillTo(DEPTH - 20); chkFlags("R8");
    masterReset(0, 0, 0);
    ofsLoad = 1'b1; wrData = (36'(20) << 18) | 36'(5); step; ofsLoad = 1'b0;
    fillTo(8); chkFlags("R8"); fillTo(9); chkFlags("R8");

    // R9: serial load with a gap and surplus bits
    masterReset(0, 0, 2);
    serialBits(3, 5);
    serData = 1'b1; step;               // serEn low: no bit taken
    serialBits(3 >> 5, OFS_W - 5);
    serialBits(40, OFS_W);
    serialBits(32'hFFFF, 4);            // beyond 2*OFS_W: ignored
    aeM = 3; afM = 40;
    fillTo(3); chkFlags("R9"); fillTo(4); chkFlags("R9");
    fillTo(DEPTH - 41); chkFlags("R9"); fillTo(DEPTH - 40); chkFlags("R9");

    // R10: partial reset keeps offsets and mode
    rstPartialN = 1'b0; step; rstPartialN = 1'b1; step;
    q.delete(); hist.delete();
    chkFlags("R10");
    fillTo(3); chkFlags("R10"); fillTo(4); chkFlags("R10");
    masterReset(1, 0, 0);
    fillTo(2);
    rstPartialN = 1'b0; step; rstPartialN = 1'b1; step;
    q.delete(); hist.delete();
    w = mkWord(seq); seq++;
    wrEn = 1'b1; wrData = w; step; wrEn = 1'b0; q.push_back(w);
    chk("R10", "rdFlag one edge after write", rdFlag, 0);
    step;
    chk("R10", "fall-through kept", rdData, w);

    // R11: retransmit in standard mode with a write on the same edge
    masterReset(0, 0, 0);
    fillTo(5);
    for (int i = 0; i < 3; i++) readOne("R11");
    retx = 1'b1; wrEn = 1'b1; wrData = 36'h123456789; step; retx = 1'b0; wrEn = 1'b0;
    q = hist;
    chkFlags("R11");
    while (q.size() > 0) readOne("R11");
    chk("R11", "rdFlag after replay", rdFlag, 0);

    // R11: retransmit in fall-through mode
    masterReset(1, 0, 0);
    fillTo(4); settle;
    for (int i = 0; i < 2; i++) readOne("R11");
    retx = 1'b1; step; retx = 1'b0;
    chk("R11", "shown word dropped", rdFlag, 0);
    q = hist;
    chkFlags("R11");
    while (q.size() > 0) readOne("R11");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule